// File: doc/BRIEF.md
# Deadline-Aware Four-Class Memory Request Arbiter

This block decides which of several requesters gets the next memory access slot. Requesters are either processor cores or fixed-function engines. Each pending request is sorted each cycle into one of four ordered classes, and the highest non-empty class wins. The class depends on the requester kind, on how close an engine is to missing its deadline, and on whether a core is flagged as memory hungry. The bench drives the hunger flag directly; the block does not measure it.

Every requester has its own budget counter. The counter counts down while its request waits and is reloaded when the request is served. An engine becomes urgent when its counter drops below a threshold. There are two thresholds, one for engines tagged with a tight deadline and one for engines tagged with a relaxed deadline. Inside a class, a rotating pointer spreads grants fairly. The grant, the valid flag and the winning class are registered, so they appear one cycle after the requests they answer. A requester is expected to present a request for one cycle per access it wants.

Top module: `mem_class_arbiter`

## Requirements
- R1: While `rst` is high, and on the first cycle after an edge where `rst` was high, `gnt` is all zero, `gnt_vld` is 0 and `gnt_cls` is 0.
- R2: If no `req` bit is set at a clock edge, then after that edge `gnt` is zero, `gnt_vld` is 0 and `gnt_cls` is 0. If any `req` bit is set, `gnt_vld` is 1 after that edge.
- R3: `gnt` has at most one bit set, and `gnt_vld` is 1 exactly when one bit is set.
- R4: The class codes on `gnt_cls` are: 0 for an urgent engine, 1 for a core with `cpu_heavy`=0, 2 for a non-urgent engine, and 3 for a core with `cpu_heavy`=1. A requester with `src_ip`=1 is an engine and one with `src_ip`=0 is a core. An urgent engine request always wins over every other class.
- R5: A request with a lower class code always wins over one with a higher code. In order: light core before relaxed engine, and relaxed engine before heavy core.
- R6: An engine is urgent when its counter is strictly less than `thr_short` (if `ip_short`=1) or `thr_long` (if `ip_short`=0).
- R7: At each edge where a requester's `req` is set and it is not granted, its counter decreases by one, stopping at zero. When its `req` is clear, the counter holds.
- R8: A counter is loaded with that requester's `budget` field during reset and at every edge where that requester is granted.
- R9: Each class has its own rotating pointer, which is 0 after reset. The winner is the first requester of the winning class at or after that class's pointer, wrapping from index N-1 to 0. After a grant, that class's pointer moves to the winner index plus one, modulo N.
- R10: The result computed from the inputs at one edge appears on `gnt`, `gnt_vld` and `gnt_cls` right after that edge and holds for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N | Request valid, one bit per requester |
| src_ip | input | N | 1 = fixed-function engine, 0 = processor core |
| ip_short | input | N | Engine deadline tag: 1 = tight, 0 = relaxed |
| cpu_heavy | input | N | Core memory-hungry flag |
| budget | input | N*CNT_W | Per-requester counter reload value |
| thr_short | input | CNT_W | Urgency threshold for tight-deadline engines |
| thr_long | input | CNT_W | Urgency threshold for relaxed-deadline engines |
| gnt | output | N | One-hot grant |
| gnt_vld | output | 1 | A grant was issued |
| gnt_cls | output | 2 | Class of the granted request |

## Verification
The bench creates every class at the same time and removes them one by one. A priority comparator that is wrong shows up here as a heavy core or a relaxed engine winning too early. It runs a waiting engine against a light core until the engine's counter crosses the threshold. A counter that is off by one, uses the wrong threshold, or never reloads shows up as the engine overtaking the core on the wrong cycle, or never yielding back to it. Long random runs compare every cycle against a reference model. A single shared pointer, or a pointer that does not step past the winner, shows up as a grant going to the wrong index within a class.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    CLS_URGENT_IP  = 2'd0,
    CLS_LIGHT_CPU  = 2'd1,
    CLS_RELAXED_IP = 2'd2,
    CLS_HEAVY_CPU  = 2'd3
  } arb_cls_e;
  localparam int NUM_CLS = 4;
endpackage

// File: rtl/arb_deadline_ctr.sv
module arb_deadline_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             won,
  input  logic             is_short,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] thr_short,
  input  logic [CNT_W-1:0] thr_long,
  output logic             urgent
);
  logic [CNT_W-1:0] left_q;

  // R7 R8: reload on reset or win, count down while waiting, stop at zero
  always_ff @(posedge clk) begin
    if (rst || won)
      left_q <= reload;
    else if (req && left_q != '0)
      left_q <= left_q - 1'b1;
  end

  // R6: the threshold is picked by the deadline tag
  assign urgent = left_q < (is_short ? thr_short : thr_long);
endmodule

// File: rtl/arb_class_map.sv
module arb_class_map
  import arb_pkg::*;
(
  input  logic     is_ip,
  input  logic     heavy,
  input  logic     urgent,
  output arb_cls_e cls
);
  always_comb begin
    if (is_ip) cls = urgent ? CLS_URGENT_IP : CLS_RELAXED_IP;
    else       cls = heavy  ? CLS_HEAVY_CPU : CLS_LIGHT_CPU;
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] start,
  output logic [N-1:0]  pick,
  output logic [IW-1:0] pick_idx,
  output logic          found
);
  always_comb begin
    pick     = '0;
    pick_idx = '0;
    found    = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(start) + k) % N;
      if (!found && mask[idx]) begin
        found     = 1'b1;
        pick[idx] = 1'b1;
        pick_idx  = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/mem_class_arbiter.sv
module mem_class_arbiter
  import arb_pkg::*;
#(
  parameter int N     = 4,
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          req,
  input  logic [N-1:0]          src_ip,
  input  logic [N-1:0]          ip_short,
  input  logic [N-1:0]          cpu_heavy,
  input  logic [N-1:0][CNT_W-1:0] budget,
  input  logic [CNT_W-1:0]      thr_short,
  input  logic [CNT_W-1:0]      thr_long,
  output logic [N-1:0]          gnt,
  output logic                  gnt_vld,
  output logic [1:0]            gnt_cls
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  arb_cls_e         cls_of [N];
  logic [N-1:0]     urgent;
  logic [N-1:0]     win_now;
  logic [N-1:0]     cls_mask [NUM_CLS];
  logic [IW-1:0]    ptr_q [NUM_CLS];
  logic [1:0]       best;
  logic             any_req;
  logic [IW-1:0]    win_idx;
  logic             found;

  for (genvar i = 0; i < N; i++) begin : g_req
    arb_deadline_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk(clk), .rst(rst), .req(req[i]), .won(win_now[i]),
      .is_short(ip_short[i]), .reload(budget[i]),
      .thr_short(thr_short), .thr_long(thr_long), .urgent(urgent[i])
    );
    arb_class_map map_i (
      .is_ip(src_ip[i]), .heavy(cpu_heavy[i]), .urgent(urgent[i]), .cls(cls_of[i])
    );
  end

  // R4 R5: per-class request masks, lowest code wins
  always_comb begin
    for (int c = 0; c < NUM_CLS; c++)
      for (int i = 0; i < N; i++)
        cls_mask[c][i] = req[i] && (int'(cls_of[i]) == c);
    best    = 2'd0;
    any_req = 1'b0;
    for (int c = NUM_CLS - 1; c >= 0; c--)
      if (|cls_mask[c]) begin
        best    = 2'(c);
        any_req = 1'b1;
      end
  end

  arb_rr_pick #(.N(N), .IW(IW)) pick_i (
    .mask(cls_mask[best]), .start(ptr_q[best]),
    .pick(win_now), .pick_idx(win_idx), .found(found)
  );

  // R9: one rotating pointer per class
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CLS; c++) ptr_q[c] <= '0;
    end else if (any_req && found) begin
      ptr_q[best] <= (int'(win_idx) == N - 1) ? '0 : win_idx + 1'b1;
    end
  end

  // R1 R2 R10: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      gnt     <= '0;
      gnt_vld <= 1'b0;
      gnt_cls <= 2'd0;
    end else begin
      gnt     <= win_now;
      gnt_vld <= found;
      gnt_cls <= found ? best : 2'd0;
    end
  end
endmodule

// File: rtl/mem_class_arbiter_chk.sv
module mem_class_arbiter_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req,
  input logic [N-1:0] gnt,
  input logic         gnt_vld,
  input logic [1:0]   gnt_cls
);
  AST_RST_QUIET: assert property (@(posedge clk) rst |=> (!gnt_vld && gnt == '0)); // R1
  AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |=> (!gnt_vld && gnt_cls == 2'd0)); // R2
  AST_BUSY_GNT: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |=> gnt_vld); // R2
  AST_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt)); // R3
  AST_VLD_MATCH: assert property (@(posedge clk) disable iff (rst)
    gnt_vld == ($countones(gnt) == 1)); // R3
  AST_GNT_WAS_REQ: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |=> ((gnt & $past(req)) != '0)); // R10
endmodule

bind mem_class_arbiter mem_class_arbiter_chk #(.N(N)) chk_i (
  .clk(clk), .rst(rst), .req(req), .gnt(gnt), .gnt_vld(gnt_vld), .gnt_cls(gnt_cls)
);

// File: tb/mem_class_arbiter_tb_top.sv
`timescale 1ns/1ps
module mem_class_arbiter_tb_top;
  localparam int N = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req = '0, src_ip, ip_short, cpu_heavy = '0;
  logic [N-1:0][W-1:0] budget;
  logic [W-1:0] thr_short, thr_long;
  logic [N-1:0] gnt;
  logic gnt_vld;
  logic [1:0] gnt_cls;

  always #2.5 clk = ~clk;

  mem_class_arbiter #(.N(N), .CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .req(req), .src_ip(src_ip), .ip_short(ip_short),
    .cpu_heavy(cpu_heavy), .budget(budget), .thr_short(thr_short),
    .thr_long(thr_long), .gnt(gnt), .gnt_vld(gnt_vld), .gnt_cls(gnt_cls)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int mcnt [N];
  int mptr [4];
  logic [N-1:0] e_gnt;
  logic e_vld;
  logic [1:0] e_cls;
  bit have_exp = 0;
  string e_tag;

  task automatic check(string tag);
    checks++;
    if (gnt !== e_gnt || gnt_vld !== e_vld || gnt_cls !== e_cls) begin
      errors++;
      $display("FAIL %s: gnt=%b vld=%b cls=%0d expected gnt=%b vld=%b cls=%0d",
               tag, gnt, gnt_vld, gnt_cls, e_gnt, e_vld, e_cls);
    end
  endtask

  function automatic int class_of(int i);
    if (src_ip[i]) begin
      int th;
      th = ip_short[i] ? int'(thr_short) : int'(thr_long);
      return (mcnt[i] < th) ? 0 : 2;
    end
    return cpu_heavy[i] ? 3 : 1;
  endfunction

  // reference model: predict the next outputs and advance its state
  task automatic predict();
    int top_c, win;
    int cl [N];
    top_c = 4; win = -1;
    for (int i = 0; i < N; i++) begin
      cl[i] = class_of(i);
      if (req[i] && cl[i] < top_c) top_c = cl[i];
    end
    if (top_c < 4)
      for (int k = 0; k < N; k++) begin
        int j;
        j = (mptr[top_c] + k) % N;
        if (win < 0 && req[j] && cl[j] == top_c) win = j;
      end
    for (int i = 0; i < N; i++)
      if (i == win) mcnt[i] = int'(budget[i]);
      else if (req[i] && mcnt[i] > 0) mcnt[i] = mcnt[i] - 1;
    e_gnt = '0;
    e_vld = (win >= 0);
    e_cls = 2'd0;
    if (win >= 0) begin
      e_gnt[win] = 1'b1;
      e_cls = 2'(top_c);
      mptr[top_c] = (win + 1) % N;
    end
  endtask

  task automatic step(logic [N-1:0] r, logic [N-1:0] h, string tag);
    @(negedge clk);
    if (have_exp) check(e_tag);
    req = r; cpu_heavy = h;
    predict();
    have_exp = 1; e_tag = tag;
  endtask

  initial begin
    src_ip   = 4'b1100;
    ip_short = 4'b0100;
    budget[0] = 8'd7; budget[1] = 8'd7; budget[2] = 8'd6; budget[3] = 8'd9;
    thr_short = 8'd255; thr_long = 8'd0;
    repeat (3) @(negedge clk);
    e_gnt = '0; e_vld = 0; e_cls = 0;
    check("R1");
    for (int i = 0; i < N; i++) mcnt[i] = int'(budget[i]);
    for (int c = 0; c < 4; c++) mptr[c] = 0;
    rst = 1'b0;
    // engine 2 urgent (tight), engine 3 relaxed, core 0 light, core 1 heavy
    step(4'b1111, 4'b0010, "R4");
    step(4'b1011, 4'b0010, "R5");
    step(4'b1010, 4'b0010, "R5");
    step(4'b0010, 4'b0010, "R5");
    step(4'b0000, 4'b0000, "R2");
    step(4'b0001, 4'b0000, "R10");
    step(4'b0000, 4'b0000, "R10");
    for (int n = 0; n < 4; n++) step(4'b0011, 4'b0000, "R9");
    for (int n = 0; n < 4; n++) step(4'b0011, 4'b0011, "R9");
    // engine 3 waits against a light core until it turns urgent
    thr_short = 8'd0; thr_long = 8'd4;
    for (int n = 0; n < 16; n++) step(4'b1001, 4'b0000, "R6/R7/R8");
    for (int n = 0; n < 3; n++) step(4'b0001, 4'b0000, "R7");
    for (int n = 0; n < 8; n++) step(4'b1001, 4'b0000, "R6/R7/R8");
    // random mix
    thr_short = 8'd3; thr_long = 8'd5;
    void'($urandom(32'd1234));
    for (int n = 0; n < 2000; n++)
      step(4'($urandom()) & 4'($urandom()|$urandom()), 4'($urandom()), "R3/R4/R5/R7/R9");
    step(4'b0000, 4'b0000, "R2");
    @(negedge clk);
    check(e_tag);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule